// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec

This block guards a 16-bit word with five even-parity check bits, giving a 21-bit codeword. It has two independent paths that can run in the same cycle. The encoder turns a data word into a codeword. The decoder takes a codeword that may have been corrupted in storage or transit. It works out which check groups fail, flips the bit that those groups point to, and returns the repaired data along with the syndrome and an error indication.

Each path is qualified by its own valid input. The result appears one clock after the request, together with an output valid. The number of check bits is derived from the data width as the smallest r that satisfies m + r + 1 <= 2^r.

Top module: `hsec_top`

## Requirements
- R1: Codeword positions are numbered 1 to 21 starting at the leftmost bit, so position p sits at vector index 21-p. Positions 1, 2, 4, 8 and 16 hold check bits. The data bits fill the remaining positions in ascending order, with the data MSB at position 3 and the data LSB at position 21. For example, data 16'h8000 encodes to 21'h1C0000 and data 16'h0001 encodes to 21'h120021.
- R2: Each check position c makes the set of positions p with (p & c) != 0 contain an even number of ones.
- R3: Decoding an unaltered codeword gives syndrome 0, an error flag of 0, and the original data.
- R4: If exactly one position p (1 to 21) of a codeword is inverted, decoding gives syndrome p and an error flag of 1, and the returned data equals the original data.
- R5: A nonzero syndrome above 21 gives an error flag of 1. In that case no bit is inverted, and the data read from the received word's data positions is passed through unchanged.
- R6: Each path's output valid is high exactly in the cycle after its input valid was high. The results update on that edge only and otherwise hold their values.
- R7: After reset, both output valids are 0 and the codeword, data, syndrome and error outputs are all 0.
- R8: The encoder and decoder paths accept requests in the same cycle and produce results that do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encValid | input | 1 | Encode request |
| encData | input | 16 | Data word to encode |
| decValid | input | 1 | Decode request |
| decCode | input | 21 | Received codeword, position 1 at the MSB |
| encOutValid | output | 1 | Encoded result valid |
| encCode | output | 21 | Encoded codeword |
| decOutValid | output | 1 | Decoded result valid |
| decData | output | 16 | Corrected data |
| decSyndrome | output | 5 | Sum of the failing check positions |
| decError | output | 1 | Nonzero syndrome seen |

## Verification
The bench builds the block with its default 16-bit data width, which gives five check bits and a 21-position codeword. At this size every one of the 21 single-bit corruptions can be tried exhaustively on one word. Two-bit corruptions can drive the syndrome into the unused range 22 to 31, which exercises the pass-through behaviour. Two hand-derived codewords pin down the bit ordering, independent of the bench's own encoder model.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } hsecStrobe_t;

  // Smallest r with m + r + 1 <= 2**r
  function automatic int chkBits(int m);
    for (int r = 1; r < 31; r++) begin
      if ((m + r + 1) <= (1 << r)) return r;
    end
    return 31;
  endfunction

endpackage

// File: rtl/hsec_ctrl.sv
module hsec_ctrl
  import hsec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        encValid,
  input  logic        decValid,
  output hsecStrobe_t strobe,
  output logic        encOutValid,
  output logic        decOutValid
);

  always_comb begin
    strobe.encLoad = encValid;
    strobe.decLoad = decValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      encOutValid <= encValid;
      decOutValid <= decValid;
    end
  end

  // R6: output valid follows input valid by one cycle
  a_r6_enc_follow: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> encOutValid);
  a_r6_dec_follow: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> !decOutValid);

endmodule

// File: rtl/hsec_datapath.sv
module hsec_datapath
  import hsec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 5,
  parameter int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsecStrobe_t       strobe,
  input  logic [DATA_W-1:0] encData,
  input  logic [CODE_W-1:0] decCode,
  output logic [CODE_W-1:0] encCode,
  output logic [DATA_W-1:0] decData,
  output logic [CHK_W-1:0]  decSyndrome,
  output logic              decError
);

  function automatic logic [CODE_W-1:0] encodeWord(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    logic              par;
    int                k;
    w = '0;
    k = DATA_W - 1;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[CODE_W-p] = d[k];
        k--;
      end
    end
    for (int i = 0; i < CHK_W; i++) begin
      par = 1'b0;
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> i) & 1) != 0) par = par ^ w[CODE_W-p];
      end
      w[CODE_W-(1 << i)] = par;
    end
    return w;
  endfunction

  function automatic logic [CHK_W-1:0] syndromeOf(logic [CODE_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int i = 0; i < CHK_W; i++) begin
      for (int p = 1; p <= CODE_W; p++) begin
        if (((p >> i) & 1) != 0) s[i] = s[i] ^ w[CODE_W-p];
      end
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] extractData(logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int                k;
    d = '0;
    k = DATA_W - 1;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = w[CODE_W-p];
        k--;
      end
    end
    return d;
  endfunction

  logic [CHK_W-1:0]  synNow;
  logic [CODE_W-1:0] flipMask;
  logic [DATA_W-1:0] fixedData;

  always_comb begin
    synNow = syndromeOf(decCode);
    // one-hot flip mask, empty when syndrome is 0 or out of range
    for (int p = 1; p <= CODE_W; p++) begin
      flipMask[CODE_W-p] = (int'(synNow) == p);
    end
    fixedData = extractData(decCode ^ flipMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encCode     <= '0;
      decData     <= '0;
      decSyndrome <= '0;
      decError    <= 1'b0;
    end else begin
      if (strobe.encLoad) encCode <= encodeWord(encData);
      if (strobe.decLoad) begin
        decData     <= fixedData;
        decSyndrome <= synNow;
        decError    <= (synNow != '0);
      end
    end
  end

  // R2: every freshly encoded word has a clean syndrome
  a_r2_clean_code: assert property (@(posedge clk) disable iff (!rstN)
    strobe.encLoad |=> (syndromeOf(encCode) == '0));
  // R3: zero syndrome means the received word is exactly the re-encoded data
  a_r3_no_change: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decLoad |=> ((decSyndrome != '0) || (encodeWord(decData) == $past(decCode))));
  // R4: a corrected word is one bit away from the received word
  a_r4_one_flip: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decLoad |=> ((decSyndrome == '0) || (int'(decSyndrome) > CODE_W) ||
      ($countones(encodeWord(decData) ^ $past(decCode)) == 1)));
  // R6: results hold while no request arrives
  a_r6_enc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.encLoad |=> $stable(encCode));
  a_r6_dec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.decLoad |=> ($stable(decData) && $stable(decSyndrome) && $stable(decError)));

endmodule

// File: rtl/hsec_top.sv
module hsec_top
  import hsec_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CHK_W  = chkBits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValid,
  input  logic [DATA_W-1:0] encData,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decCode,
  output logic              encOutValid,
  output logic [CODE_W-1:0] encCode,
  output logic              decOutValid,
  output logic [DATA_W-1:0] decData,
  output logic [CHK_W-1:0]  decSyndrome,
  output logic              decError
);

  hsecStrobe_t strobe;

  hsec_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .encValid    (encValid),
    .decValid    (decValid),
    .strobe      (strobe),
    .encOutValid (encOutValid),
    .decOutValid (decOutValid)
  );

  hsec_datapath #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .CODE_W (CODE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .encData     (encData),
    .decCode     (decCode),
    .encCode     (encCode),
    .decData     (decData),
    .decSyndrome (decSyndrome),
    .decError    (decError)
  );

  // R7: both valids low in the cycle after reset
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!encOutValid && !decOutValid));

endmodule

// File: tb/hsec_top_bench.sv
module hsec_top_bench;

  localparam int DW = 16;
  localparam int CW = 21;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          encValid = 1'b0;
  logic [DW-1:0] encData = '0;
  logic          decValid = 1'b0;
  logic [CW-1:0] decCode = '0;
  logic          encOutValid;
  logic [CW-1:0] encCode;
  logic          decOutValid;
  logic [DW-1:0] decData;
  logic [SW-1:0] decSyndrome;
  logic          decError;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  hsec_top u_hsec_top (
    .clk (clk), .rstN (rstN),
    .encValid (encValid), .encData (encData),
    .decValid (decValid), .decCode (decCode),
    .encOutValid (encOutValid), .encCode (encCode),
    .decOutValid (decOutValid), .decData (decData),
    .decSyndrome (decSyndrome), .decError (decError)
  );

  // vector table: {data, first flip position, second flip position}, 0 = none
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {16'h0000, 5'd0,  5'd0},
    {16'hFFFF, 5'd0,  5'd0},
    {16'hA5A5, 5'd3,  5'd0},
    {16'h1234, 5'd16, 5'd0},
    {16'h8001, 5'd21, 5'd0},
    {16'h7E18, 5'd1,  5'd0},
    {16'h0000, 5'd16, 5'd15},
    {16'hC3A9, 5'd20, 5'd2}
  };

  // reference model written from R1/R2: positions held in a 1-based array
  function automatic logic [CW-1:0] refEncode(logic [DW-1:0] d);
    logic        slot [1:CW];
    logic [CW-1:0] v;
    int          nextBit;
    nextBit = DW - 1;
    for (int p = 1; p <= CW; p++) begin
      if (p == 1 || p == 2 || p == 4 || p == 8 || p == 16) slot[p] = 1'b0;
      else begin slot[p] = d[nextBit]; nextBit--; end
    end
    for (int c = 1; c <= 16; c = c * 2) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p <= CW; p++) if ((p & c) != 0 && p != c) acc ^= slot[p];
      slot[c] = acc;
    end
    for (int p = 1; p <= CW; p++) v[CW-p] = slot[p];
    return v;
  endfunction

  function automatic logic [DW-1:0] refData(logic [CW-1:0] v);
    logic [DW-1:0] d;
    int            nextBit;
    d = '0;
    nextBit = DW - 1;
    for (int p = 1; p <= CW; p++) begin
      if (!(p == 1 || p == 2 || p == 4 || p == 8 || p == 16)) begin
        d[nextBit] = v[CW-p]; nextBit--;
      end
    end
    return d;
  endfunction

  function automatic logic [CW-1:0] posMask(int p);
    logic [CW-1:0] m;
    m = '0;
    if (p >= 1 && p <= CW) m[CW-p] = 1'b1;
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runEnc(input logic [DW-1:0] d);
    @(negedge clk); encValid = 1'b1; encData = d;
    @(negedge clk); encValid = 1'b0;
  endtask

  task automatic runDec(input logic [CW-1:0] c);
    @(negedge clk); decValid = 1'b1; decCode = c;
    @(negedge clk); decValid = 1'b0;
  endtask

  task automatic checkDecode(input logic [CW-1:0] rx, input logic [DW-1:0] orig, input string tag);
    int syn;
    logic [DW-1:0] expData;
    syn = 0;
    for (int c = 1; c <= 16; c = c * 2) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p <= CW; p++) if ((p & c) != 0) acc ^= rx[CW-p];
      if (acc) syn += c;
    end
    expData = (syn > CW) ? refData(rx) : orig;
    check(decOutValid == 1'b1, {tag, " R6 valid"}, 32'(decOutValid), 1);
    check(int'(decSyndrome) == syn, {tag, " syndrome"}, 32'(decSyndrome), 32'(syn));
    check(decError == (syn != 0), {tag, " error flag"}, 32'(decError), 32'(syn != 0));
    check(decData == expData, {tag, " data"}, 32'(decData), 32'(expData));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R7: reset state
    check(encOutValid == 0 && decOutValid == 0, "R7 valids", {30'd0, encOutValid, decOutValid}, 0);
    check(encCode == 0, "R7 encCode", 32'(encCode), 0);
    check(decData == 0 && decSyndrome == 0 && decError == 0, "R7 decoder outputs",
          32'(decData), 0);
    rstN = 1'b1;

    // R1: hand-derived codewords
    runEnc(16'h8000);
    check(encCode == 21'h1C0000, "R1 msb at position 3", 32'(encCode), 32'h1C0000);
    runEnc(16'h0001);
    check(encCode == 21'h120021, "R1 lsb at position 21", 32'(encCode), 32'h120021);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] d;
      logic [CW-1:0] code, rx;
      d    = VEC[i][25:10];
      code = refEncode(d);
      runEnc(d);
      check(encOutValid == 1'b1, "R6 enc valid", 32'(encOutValid), 1);
      check(encCode == code, "R1 encode", 32'(encCode), 32'(code));
      for (int c = 1; c <= 16; c = c * 2) begin
        int ones;
        ones = 0;
        for (int p = 1; p <= CW; p++) if ((p & c) != 0) ones += int'(encCode[CW-p]);
        check((ones % 2) == 0, "R2 even group", 32'(ones), 0);
      end
      rx = code ^ posMask(int'(VEC[i][9:5])) ^ posMask(int'(VEC[i][4:0]));
      runDec(rx);
      checkDecode(rx, d, (VEC[i][4:0] != 0) ? "R5 double flip" :
                         (VEC[i][9:5] != 0) ? "R4 single flip" : "R3 clean");
    end

    // R4: every single position on one word
    for (int p = 1; p <= CW; p++) begin
      logic [CW-1:0] rx;
      rx = refEncode(16'h5C3E) ^ posMask(p);
      runDec(rx);
      checkDecode(rx, 16'h5C3E, "R4 sweep");
    end

    // R5: syndrome 31 from flips at 16 and 15 on zero data
    runDec(posMask(16) | posMask(15));
    check(decSyndrome == 5'd31, "R5 syndrome 31", 32'(decSyndrome), 31);
    check(decError == 1'b1, "R5 flag", 32'(decError), 1);
    check(decData == 16'h0020, "R5 passthrough", 32'(decData), 32'h0020);

    // R6: no request -> valids low, outputs hold
    @(negedge clk);
    encData = 16'hFFFF; decCode = '1;
    @(negedge clk);
    check(encOutValid == 0 && decOutValid == 0, "R6 idle valids",
          {30'd0, encOutValid, decOutValid}, 0);
    check(encCode == 21'h120021 || encCode == refEncode(VEC[NV-1][25:10]),
          "R6 enc hold", 32'(encCode), 32'(refEncode(VEC[NV-1][25:10])));
    check(decSyndrome == 5'd31 && decData == 16'h0020, "R6 dec hold", 32'(decData), 32'h0020);

    // R8: both paths in the same cycle
    @(negedge clk);
    encValid = 1'b1; encData = 16'h0F0F;
    decValid = 1'b1; decCode = refEncode(16'hBEEF) ^ posMask(9);
    @(negedge clk);
    encValid = 1'b0; decValid = 1'b0;
    check(encCode == refEncode(16'h0F0F), "R8 enc concurrent", 32'(encCode), 32'(refEncode(16'h0F0F)));
    check(decData == 16'hBEEF && decSyndrome == 5'd9, "R8 dec concurrent", 32'(decData), 32'hBEEF);
    check(encOutValid && decOutValid, "R8 both valid", {30'd0, encOutValid, decOutValid}, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule